// File: doc/BRIEF.md
# Frequency-Change Clock Hold-Off Gate

This block sits between a programmable on-chip oscillator and the system clock tree. Software writes a frequency code and a range code from its register clock domain. The block carries each new pair into the oscillator clock domain and presents it to the oscillator as the applied setting. Whenever the applied pair changes, the block holds the outgoing clock low for a fixed number of oscillator cycles so that the oscillator can settle. It then lets the clock through again at the new setting.

The outgoing clock passes through a glitch-free gate, so every pulse that reaches the system is a whole oscillator high phase. A busy flag is high for exactly the oscillator cycles whose pulses are withheld. The flag drops in the cycle whose pulse is the first one released. A change that arrives while a hold is already running restarts the count, so the oscillator settles again on the latest pair. One frequency code is reserved: writing it leaves the frequency unchanged and still updates the range.

Top module: `fsel_hold_gate`

## Requirements
- R1: While `rst_n` is low, the applied frequency and range equal their reset values (0 and 0 by default), `busy` is high and `clk_out` stays low. After reset is released, `busy` is low and `clk_out` follows `osc_clk`.
- R2: A write whose frequency code is 0, 1 or 2 and differs from the applied frequency makes `freq_o` take that code at the end of a hold.
- R3: A write that changes only the range code also triggers a hold, and `range_o` takes the new code.
- R4: A single change withholds exactly `HOLD_CYC` (default 4) consecutive oscillator high phases. `busy` is high during exactly those cycles.
- R5: A write that equals the applied pair starts no hold. `busy` stays low and no oscillator pulse is withheld.
- R6: The frequency code 3 (all ones) is reserved. Writing it keeps the previous frequency, and `freq_o` never shows it. The range field of the same write still applies.
- R7: A change that arrives during a running hold restarts the count. The hold then lasts longer than `HOLD_CYC` cycles and ends with the latest pair applied.
- R8: `busy`, and with it the gate enable, changes only while `osc_clk` is low.
- R9: `freq_o` and `range_o` change only inside a hold, never in a cycle whose pulse is released.
- R10: `clk_out` is never high while `busy` is high. Every oscillator high phase outside a hold reaches `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, sampled on `reg_clk` |
| wr_freq | input | FREQ_W | Frequency code to write |
| wr_range | input | RANGE_W | Range code to write |
| osc_clk | input | 1 | Oscillator clock |
| freq_o | output | FREQ_W | Frequency code applied to the oscillator |
| range_o | output | RANGE_W | Range code applied to the oscillator |
| clk_out | output | 1 | Gated clock to the system |
| busy | output | 1 | High for each oscillator cycle whose pulse is withheld |

## Verification
The bench goes after the exact length of a single hold. A design with an off-by-one counter would withhold three or five pulses instead of four. Writes that leave the pair unchanged, including a reserved frequency code with an unchanged range, must start no hold; a detector that compares against the wrong value would withhold pulses for nothing. A second change is placed inside a running hold, so a design that ignores it or fails to restart the count ends too early or applies a stale pair. Every sampled high phase is also checked against `busy`, which catches a gate that lets a runt pulse through or drops a pulse outside a hold.

// File: rtl/fhg_pkg.sv
package fhg_pkg;
   localparam int GATE_LATCH = 0;
   localparam int GATE_FLOP  = 1;

   function automatic bit code_allowed(int code, int reserved);
      return code != reserved;
   endfunction
endpackage

// File: rtl/fhg_cfg_reg.sv
module fhg_cfg_reg #(
   parameter int FREQ_W    = 2,
   parameter int RANGE_W   = 3,
   parameter int RSVD_CODE = 3,
   parameter int FREQ_RST  = 0,
   parameter int RANGE_RST = 0
) (
   input  logic               reg_clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FREQ_W-1:0]  wr_freq,
   input  logic [RANGE_W-1:0] wr_range,
   output logic [FREQ_W-1:0]  freq_q,
   output logic [RANGE_W-1:0] range_q
);
   localparam logic [FREQ_W-1:0] RSVD_V = FREQ_W'(RSVD_CODE);

   always_ff @(posedge reg_clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_q  <= FREQ_W'(FREQ_RST);
         range_q <= RANGE_W'(RANGE_RST);
      end else if (wr_en) begin
         if (wr_freq != RSVD_V) freq_q <= wr_freq;
         range_q <= wr_range;
      end
   end
endmodule

// File: rtl/fhg_bus_sync.sv
module fhg_bus_sync #(
   parameter int             W       = 5,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= RST_VAL;
            else        stg <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= {STAGES{RST_VAL}};
            else        stg <= {stg[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fhg_hold_ctl.sv
module fhg_hold_ctl #(
   parameter int           W        = 5,
   parameter int           HOLD_CYC = 4,
   parameter logic [W-1:0] RST_VAL  = '0
) (
   input  logic         osc_clk,
   input  logic         rst_n,
   input  logic [W-1:0] target,
   output logic [W-1:0] applied,
   output logic         en_d
);
   localparam int            CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             chg;

   assign chg = (target != applied);

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         applied <= RST_VAL;
         cnt     <= '0;
      end else if (chg) begin
         applied <= target;
         cnt     <= LOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign en_d = rst_n && !chg && (cnt == '0);
endmodule

// File: rtl/fhg_clk_gate.sv
module fhg_clk_gate #(
   parameter int STYLE = 0
) (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic en_d,
   output logic clk_out,
   output logic busy
);
   logic en_q;

   generate
      if (STYLE == fhg_pkg::GATE_LATCH) begin : g_latch
         always_latch begin
            if (!osc_clk) en_q = en_d;
         end
      end else begin : g_flop
         always_ff @(negedge osc_clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en_d;
         end
      end
   endgenerate

   assign clk_out = osc_clk & en_q;
   assign busy    = ~en_q;
endmodule

// File: rtl/fsel_hold_gate.sv
module fsel_hold_gate #(
   parameter int FREQ_W      = 2,
   parameter int RANGE_W     = 3,
   parameter int RSVD_CODE   = 3,
   parameter int FREQ_RST    = 0,
   parameter int RANGE_RST   = 0,
   parameter int HOLD_CYC    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int GATE_STYLE  = fhg_pkg::GATE_LATCH
) (
   input  logic               reg_clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FREQ_W-1:0]  wr_freq,
   input  logic [RANGE_W-1:0] wr_range,
   input  logic               osc_clk,
   output logic [FREQ_W-1:0]  freq_o,
   output logic [RANGE_W-1:0] range_o,
   output logic               clk_out,
   output logic               busy
);
   localparam int            BUS_W   = FREQ_W + RANGE_W;
   localparam logic [BUS_W-1:0] BUS_RST = {FREQ_W'(FREQ_RST), RANGE_W'(RANGE_RST)};

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (GATE_STYLE != fhg_pkg::GATE_LATCH && GATE_STYLE != fhg_pkg::GATE_FLOP) begin : g_bad_style
         $error("GATE_STYLE must select latch or flop gate");
      end
      if (!fhg_pkg::code_allowed(FREQ_RST, RSVD_CODE)) begin : g_bad_rst
         $error("FREQ_RST must not be the reserved code");
      end
   endgenerate

   logic [FREQ_W-1:0]  freq_q;
   logic [RANGE_W-1:0] range_q;
   logic [BUS_W-1:0]   target;
   logic [BUS_W-1:0]   applied;
   logic               en_d;

   fhg_cfg_reg #(
      .FREQ_W(FREQ_W), .RANGE_W(RANGE_W), .RSVD_CODE(RSVD_CODE),
      .FREQ_RST(FREQ_RST), .RANGE_RST(RANGE_RST)
   ) u_cfg (
      .reg_clk(reg_clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_freq(wr_freq), .wr_range(wr_range),
      .freq_q(freq_q), .range_q(range_q)
   );

   fhg_bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
      .clk(osc_clk), .rst_n(rst_n), .d({freq_q, range_q}), .q(target)
   );

   fhg_hold_ctl #(.W(BUS_W), .HOLD_CYC(HOLD_CYC), .RST_VAL(BUS_RST)) u_hold (
      .osc_clk(osc_clk), .rst_n(rst_n), .target(target),
      .applied(applied), .en_d(en_d)
   );

   fhg_clk_gate #(.STYLE(GATE_STYLE)) u_gate (
      .osc_clk(osc_clk), .rst_n(rst_n), .en_d(en_d),
      .clk_out(clk_out), .busy(busy)
   );

   assign freq_o  = applied[BUS_W-1:RANGE_W];
   assign range_o = applied[RANGE_W-1:0];
endmodule

// File: rtl/fsel_hold_gate_chk.sv
module fsel_hold_gate_chk #(
   parameter int FREQ_W    = 2,
   parameter int RANGE_W   = 3,
   parameter int RSVD_CODE = 3,
   parameter int HOLD_CYC  = 4
) (
   input logic               osc_clk,
   input logic               rst_n,
   input logic               clk_out,
   input logic               busy,
   input logic [FREQ_W-1:0]  freq_o,
   input logic [RANGE_W-1:0] range_o
);
   logic [15:0] run;
   logic        armed;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= '0;
         armed <= 1'b0;
      end else begin
         if (!busy) armed <= 1'b1;
         if (!busy)               run <= '0;
         else if (run != 16'hFFFF) run <= run + 1'b1;
      end
   end

   // R10
   no_glitch_chk: assert property (@(negedge osc_clk) disable iff (!rst_n)
      busy |-> !clk_out);

   // R10
   pass_idle_chk: assert property (@(negedge osc_clk) disable iff (!rst_n)
      !busy |-> clk_out);

   // R9
   settle_in_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !$stable({freq_o, range_o}) |-> busy);

   // R6
   no_rsvd_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
      freq_o != FREQ_W'(RSVD_CODE));

   // R4
   hold_len_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (armed && run != '0 && !busy) |-> (32'(run) >= HOLD_CYC));

   // R8
   always @(busy) begin
      if (rst_n === 1'b1) begin
         gate_low_chk: assert (osc_clk !== 1'b1);
      end
   end
endmodule

bind fsel_hold_gate fsel_hold_gate_chk #(
   .FREQ_W(FREQ_W), .RANGE_W(RANGE_W), .RSVD_CODE(RSVD_CODE), .HOLD_CYC(HOLD_CYC)
) u_chk (
   .osc_clk(osc_clk), .rst_n(rst_n), .clk_out(clk_out), .busy(busy),
   .freq_o(freq_o), .range_o(range_o)
);

// File: tb/fsel_hold_gate_bench.sv
module fsel_hold_gate_bench;
   logic       reg_clk = 1'b0;
   logic       osc_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       wr_en   = 1'b0;
   logic [1:0] wr_freq = '0;
   logic [2:0] wr_range = '0;
   logic [1:0] freq_o;
   logic [2:0] range_o;
   logic       clk_out;
   logic       busy;

   int tests = 0;
   int fails = 0;
   int holds = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic [1:0] f;
      logic [2:0] r;
      bit         rearm;
      string      tag;
   } item_t;
   item_t sb[$];
   logic [1:0] m_f = 2'd0;
   logic [2:0] m_r = 3'd0;

   always #4  reg_clk = ~reg_clk;
   always #20 osc_clk = ~osc_clk;

   fsel_hold_gate u_fsel_hold_gate (
      .reg_clk(reg_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_freq(wr_freq),
      .wr_range(wr_range), .osc_clk(osc_clk), .freq_o(freq_o),
      .range_o(range_o), .clk_out(clk_out), .busy(busy)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(logic [1:0] f, logic [2:0] r, bit merge, string tag);
      logic [1:0] nf;
      item_t it;
      nf = (f == 2'd3) ? m_f : f;
      if (nf != m_f || r != m_r) begin
         if (merge && sb.size() > 0) begin
            it = sb[$];
            it.f = nf; it.r = r; it.rearm = 1'b1; it.tag = tag;
            sb[$] = it;
         end else begin
            it.f = nf; it.r = r; it.rearm = 1'b0; it.tag = tag;
            sb.push_back(it);
         end
         m_f = nf;
         m_r = r;
      end
      @(negedge reg_clk);
      wr_en = 1'b1; wr_freq = f; wr_range = r;
      @(negedge reg_clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (18) @(posedge osc_clk);
   endtask

   // monitor: one sample per oscillator high phase
   initial begin
      int run;
      item_t it;
      run = 0;
      forever begin
         @(posedge osc_clk);
         #10;
         if (!mon_on) begin
            run = 0;
         end else if (busy) begin
            run++;
            chk(clk_out == 1'b0, "R10", "pulse leaked during hold", int'(clk_out), 0);
         end else begin
            chk(clk_out == 1'b1, "R10", "pulse dropped outside hold", int'(clk_out), 1);
            if (run > 0) begin
               holds++;
               if (sb.size() == 0) begin
                  chk(1'b0, "R5", "hold without a change", run, 0);
               end else begin
                  it = sb.pop_front();
                  chk(freq_o == it.f, it.tag, "applied freq", int'(freq_o), int'(it.f));
                  chk(range_o == it.r, it.tag, "applied range", int'(range_o), int'(it.r));
                  if (it.rearm) chk(run > 4, "R7", "re-armed hold length", run, 5);
                  else          chk(run == 4, "R4", "hold length", run, 4);
               end
               run = 0;
            end
         end
      end
   end

   initial begin
      int h;
      repeat (5) @(posedge osc_clk);
      #10;
      // R1: reset state
      chk(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
      chk(clk_out == 1'b0, "R1", "clk_out in reset", int'(clk_out), 0);
      chk(freq_o == 2'd0, "R1", "freq in reset", int'(freq_o), 0);
      chk(range_o == 3'd0, "R1", "range in reset", int'(range_o), 0);
      @(negedge reg_clk);
      rst_n = 1'b1;
      repeat (3) @(posedge osc_clk);
      #10;
      chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      chk(clk_out == 1'b1, "R1", "clk_out after reset", int'(clk_out), 1);
      mon_on = 1'b1;

      write_cfg(2'd1, 3'd0, 1'b0, "R2"); settle();
      write_cfg(2'd2, 3'd0, 1'b0, "R2"); settle();
      write_cfg(2'd0, 3'd5, 1'b0, "R2"); settle();
      write_cfg(2'd0, 3'd3, 1'b0, "R3"); settle();
      write_cfg(2'd2, 3'd3, 1'b0, "R2"); settle();

      // R5: equal value write
      h = holds;
      write_cfg(2'd2, 3'd3, 1'b0, "R5"); settle();
      chk(holds == h, "R5", "hold count after equal write", holds, h);
      chk(freq_o == 2'd2, "R5", "freq after equal write", int'(freq_o), 2);

      // R6: reserved code, same range -> nothing
      h = holds;
      write_cfg(2'd3, 3'd3, 1'b0, "R6"); settle();
      chk(holds == h, "R6", "hold count after reserved write", holds, h);
      chk(freq_o == 2'd2, "R6", "freq kept on reserved code", int'(freq_o), 2);
      // R6: reserved code with new range
      write_cfg(2'd3, 3'd6, 1'b0, "R6"); settle();

      // R7: second change inside a running hold
      write_cfg(2'd1, 3'd6, 1'b0, "R7");
      @(posedge busy);
      write_cfg(2'd0, 3'd1, 1'b1, "R7");
      settle();
      #10;
      chk(freq_o == 2'd0, "R7", "final freq after re-arm", int'(freq_o), 0);
      chk(range_o == 3'd1, "R7", "final range after re-arm", int'(range_o), 1);

      chk(sb.size() == 0, "R2", "pending expected holds", sb.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule